// File: doc/BRIEF.md
# Alarm and Error Interrupt Latch with One-Second Hold

This block turns live alarm status and error condition inputs into latched interrupt status bits for a host. There are two groups, each eight bits wide by default. An alarm bit latches on a rising edge of its live input, or on any change of that input, as chosen per bit. An error bit latches only on a rising edge. Each bit latches only while its enable is set.

Each group has its own hold mode. In read-clear mode, a latched bit stays set until the host pulses that group's read strobe. In hold mode, the bit is timed by a periodic one-second strobe and ignores host reads. A bit latched in hold mode clears at the second strobe after it was set, so it is visible for at least one whole interval.

A single interrupt request output is raised while any latched bit has its enable set. The block sits behind the alarm detectors and before the host register decode.

Top module: `alarm_irq_latch`

## Requirements
- R1: After reset every status bit and the request output are 0. The edge detectors also start from 0, so an input that is already 1 when reset ends latches its bit, if enabled, in the first clock cycle after reset.
- R2: An error status bit sets only when its error input goes from 0 to 1. An error input that stays at 1 does not set the bit again once it has been cleared.
- R3: An alarm type bit of 0 latches on a 0-to-1 change of the live alarm input. A type bit of 1 latches on any change of it, including 1 to 0.
- R4: When a bit's enable is 0, no event sets that bit, in either hold mode.
- R5: With its hold mode at 0 (read-clear), a group's status bits stay set until a clock cycle in which the group's read strobe is 1. They read 0 from the following cycle.
- R6: An event on a bit in the same cycle as a clearing read or a clearing strobe leaves that bit set.
- R7: With its hold mode at 1, a group's latched bit ignores the read strobe. It clears at the second one-second strobe after the cycle in which it was set; a strobe in the setting cycle does not count.
- R8: Alarm bit 5 has no alarm behind it: its live input is ignored and its status always reads 0.
- R9: The request output is 1 exactly when some status bit is 1 while its enable is 1. Clearing an enable hides that bit from the request but does not clear the bit.
- R10: In hold mode, a new event on a bit that is already set starts its hold again. The bit then clears at the second strobe after the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alm_live | input | W | Live alarm status (bit 5 unused) |
| err_live | input | W | Live error conditions |
| alm_en | input | W | Per-bit alarm interrupt enable |
| err_en | input | W | Per-bit error interrupt enable |
| alm_type | input | W | Per-bit alarm event type: 0 rising edge, 1 any change |
| alm_hold | input | 1 | Alarm group hold mode: 0 read-clear, 1 one-second hold |
| err_hold | input | 1 | Error group hold mode: 0 read-clear, 1 one-second hold |
| sec_tick | input | 1 | One-cycle pulse once per second |
| alm_rd | input | 1 | Host read of alarm status (clears in read-clear mode) |
| err_rd | input | 1 | Host read of error status (clears in read-clear mode) |
| alm_stat | output | W | Latched alarm interrupt status |
| err_stat | output | W | Latched error interrupt status |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default width of eight bits and the unused alarm position at bit 5. This exposes that dead bit while an all-ones live input toggles with every alarm bit in any-change mode. The strobe is driven every few cycles, so many hold intervals finish within the run. Random switching of the hold modes, enables and types then covers clears that land in the same cycle as events, reads and strobes.

// File: rtl/alarm_irq_latch.sv
module alarm_irq_latch #(
  parameter int W = 8,
  parameter int UNUSED_BIT = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] alm_live,
  input  logic [W-1:0] err_live,
  input  logic [W-1:0] alm_en,
  input  logic [W-1:0] err_en,
  input  logic [W-1:0] alm_type,
  input  logic         alm_hold,
  input  logic         err_hold,
  input  logic         sec_tick,
  input  logic         alm_rd,
  input  logic         err_rd,
  output logic [W-1:0] alm_stat,
  output logic [W-1:0] err_stat,
  output logic         irq
);
  localparam logic [W-1:0] LIVE_MASK = ~(W'(1) << UNUSED_BIT);

  logic [W-1:0] alm_in, alm_prev, err_prev, alm_aged, err_aged;
  logic [W-1:0] alm_evt, err_evt, alm_clr, err_clr;

  assign alm_in  = alm_live & LIVE_MASK;
  assign alm_evt = alm_en & ((alm_type & (alm_in ^ alm_prev)) | (~alm_type & alm_in & ~alm_prev));
  assign err_evt = err_en & err_live & ~err_prev;

  assign alm_clr = alm_hold ? (sec_tick ? alm_aged : '0) : {W{alm_rd}};
  assign err_clr = err_hold ? (sec_tick ? err_aged : '0) : {W{err_rd}};

  assign irq = |(alm_stat & alm_en) | |(err_stat & err_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_prev <= '0;
      err_prev <= '0;
      alm_stat <= '0;
      err_stat <= '0;
      alm_aged <= '0;
      err_aged <= '0;
    end else begin
      alm_prev <= alm_in;
      err_prev <= err_live;
      alm_stat <= alm_evt | (alm_stat & ~alm_clr);
      err_stat <= err_evt | (err_stat & ~err_clr);
      alm_aged <= alm_hold ? (~alm_evt & (sec_tick ? (alm_stat & ~alm_aged) : alm_aged)) : '0;
      err_aged <= err_hold ? (~err_evt & (sec_tick ? (err_stat & ~err_aged) : err_aged)) : '0;
    end
  end

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    alm_stat[UNUSED_BIT] == 1'b0);

  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> ((err_stat & $past(err_evt)) == $past(err_evt)));

  a_r4_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((alm_stat & ~$past(alm_stat) & ~$past(alm_en)) == '0));

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_hold && err_rd && err_evt == '0) |=> err_stat == '0);

  a_r7_hold_ignores_read: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_hold && alm_rd && !sec_tick && alm_evt == '0) |=> alm_stat == $past(alm_stat));
endmodule

// File: tb/alarm_irq_latch_bench.sv
module alarm_irq_latch_bench;
  localparam int W = 8;
  localparam int UB = 5;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] alm_live = 0, err_live = 0, alm_en = 0, err_en = 0, alm_type = 0;
  logic alm_hold = 0, err_hold = 0, sec_tick = 0, alm_rd = 0, err_rd = 0;
  logic [W-1:0] alm_stat, err_stat;
  logic irq;

  int vectors = 0, errors = 0;
  logic [W-1:0] am, aa, em, ea, apm, epm;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_irq_latch #(.W(W), .UNUSED_BIT(UB)) u_alarm_irq_latch (
    .clk(clk), .rst_n(rst_n), .alm_live(alm_live), .err_live(err_live),
    .alm_en(alm_en), .err_en(err_en), .alm_type(alm_type),
    .alm_hold(alm_hold), .err_hold(err_hold), .sec_tick(sec_tick),
    .alm_rd(alm_rd), .err_rd(err_rd), .alm_stat(alm_stat),
    .err_stat(err_stat), .irq(irq));

  function automatic logic [1:0] bit_next(logic s, logic a, logic ev, logic hold, logic tick, logic rd);
    if (!hold) return {ev | (s & ~rd), 1'b0};
    if (ev) return 2'b10;
    if (tick) begin
      if (s && a) return 2'b00;
      if (s) return 2'b11;
      return 2'b00;
    end
    return {s, a};
  endfunction

  task automatic model_step();
    logic [W-1:0] nam, naa, nem, nea, lv;
    logic ev;
    logic [1:0] r;
    lv = alm_live;
    lv[UB] = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (alm_type[i]) ev = alm_en[i] && (lv[i] != apm[i]);
      else ev = alm_en[i] && lv[i] && !apm[i];
      r = bit_next(am[i], aa[i], ev, alm_hold, sec_tick, alm_rd);
      nam[i] = r[1]; naa[i] = r[0];
      ev = err_en[i] && err_live[i] && !epm[i];
      r = bit_next(em[i], ea[i], ev, err_hold, sec_tick, err_rd);
      nem[i] = r[1]; nea[i] = r[0];
    end
    am = nam; aa = naa; em = nem; ea = nea; apm = lv; epm = err_live;
  endtask

  task automatic compare(string tag);
    logic exp_irq;
    exp_irq = |(am & alm_en) || |(em & err_en);
    vectors++;
    if (alm_stat !== am) begin
      errors++;
      $display("FAIL %s alm_stat actual %h expected %h", tag, alm_stat, am);
    end
    vectors++;
    if (err_stat !== em) begin
      errors++;
      $display("FAIL %s err_stat actual %h expected %h", tag, err_stat, em);
    end
    vectors++;
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, exp_irq);
    end
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    #1;
    compare(tag);
    @(negedge clk);
    sec_tick = 0; alm_rd = 0; err_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd4711);
    am = 0; aa = 0; em = 0; ea = 0; apm = 0; epm = 0;
    err_live = 8'h01; err_en = '1; alm_en = '1;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    cyc("R1 first cycle edge");
    err_rd = 1; cyc("R5 read clears");
    cyc("R2 held level no reset"); cyc("R2 held level");
    err_live = 0; cyc("R2 fall");
    err_live = 8'h01; cyc("R2 rise again");
    err_live = 8'h03; err_rd = 1; cyc("R6 event with read");
    err_rd = 1; cyc("R5 read");
    alm_type = 8'h02; alm_live = 8'h06; cyc("R3 rise both");
    alm_rd = 1; cyc("R5 alarm read");
    alm_live = 8'h00; cyc("R3 fall any-change only");
    alm_rd = 1; cyc("R5 alarm read");
    alm_en = 8'h00; alm_live = 8'h0F; cyc("R4 disabled rise");
    alm_live = 8'h00; alm_hold = 1; cyc("R4 disabled in hold");
    alm_en = '1; alm_type = '1; alm_live = '1; cyc("R8 all ones");
    alm_live = '0; cyc("R8 all zeros");
    err_en = 8'h00; cyc("R9 enable hides");
    err_en = '1; cyc("R9 enable shows");
    err_hold = 1; err_live = 8'h10; cyc("R7 set in hold");
    err_rd = 1; cyc("R7 read ignored");
    sec_tick = 1; cyc("R7 first tick keeps");
    err_live = 8'h00; cyc("R7 wait");
    err_live = 8'h10; cyc("R10 restart hold");
    sec_tick = 1; cyc("R10 first tick after restart");
    sec_tick = 1; cyc("R7 second tick clears");
    err_live = 8'h00; cyc("R7 idle");
    err_live = 8'h20; sec_tick = 1; cyc("R7 tick in setting cycle");
    sec_tick = 1; cyc("R7 tick one");
    sec_tick = 1; cyc("R7 tick two");
    for (int n = 0; n < 3000; n++) begin
      alm_live = $urandom; err_live = $urandom;
      if ($urandom_range(7) == 0) alm_en = $urandom;
      if ($urandom_range(7) == 0) err_en = $urandom;
      if ($urandom_range(7) == 0) alm_type = $urandom;
      if ($urandom_range(31) == 0) alm_hold = $urandom;
      if ($urandom_range(31) == 0) err_hold = $urandom;
      sec_tick = ($urandom_range(5) == 0);
      alm_rd = ($urandom_range(3) == 0);
      err_rd = ($urandom_range(3) == 0);
      cyc("R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule